// File: doc/BRIEF.md
# Serial Master with Auto Chip-Select

This block is a three-wire synchronous serial master (clock, data out, data in) that drives eight active-high chip-select outputs. A host reaches it through a small register port of four address bits and eight data bits. Two data bytes, a first byte and a second byte, hold the outgoing word. The same bytes receive the incoming bits, so the host can read them back when the transfer ends. The serial clock comes from the system clock through a programmable half-period divider.

Chip selects can be driven in two ways, and the two can be mixed. In software mode, the host writes a select register whose bits drive the pins one for one. The host then starts a transfer by writing the first byte. In hardware mode, the host writes the first byte through one of eight alias addresses. The alias address tells an internal sequencer which select to raise. The sequencer raises that select, waits one serial period, and shifts 8 or 16 bits. It then waits one more serial period and drops the select. This makes each peripheral look like a memory-mapped location. A completion flag can raise an interrupt.

Top module: `mwcs_top`

## Requirements
- R1: After reset, all chip-select outputs, the serial clock, data out and the interrupt are low, and the status register (0Dh) reads 0.
- R2: A write to the select register at 0Ch drives chip-select pin k from bit k of the written value, and the register reads back the same value.
- R3: Address 00h holds the second byte and 01h holds the first byte. A write to 01h loads the first byte and starts a transfer with no hardware select. A write to 02h+k (k = 0..7) loads the first byte and starts a transfer framed by chip select k. Reads of 02h..09h return the first byte.
- R4: During a hardware-framed transfer, only chip select k is high (with the select register at zero). The serial clock gives exactly 8 rising edges when control bit 0 (0Ah) is 0, or 16 when it is 1. The select is low again afterwards.
- R5: Output bits go out most significant bit first: the first byte, then (in 16-bit mode) the second byte. Data out changes only while the serial clock is low. Data in is sampled at each rising edge.
- R6: Received bits replace the outgoing ones. In 16-bit mode, the first 8 received bits go to the first byte and the next 8 to the second byte. In 8-bit mode, the received byte goes to the first byte and the second byte keeps its value.
- R7: With divider register 0Bh = D, every high phase and every low phase between bits of the serial clock lasts D+1 system clock cycles.
- R8: The serial clock idles low. A hardware select is raised at least 2(D+1) cycles before the first rising edge and dropped at least 2(D+1) cycles after the last falling edge.
- R9: Status bit 1 sets when a transfer ends. The interrupt output equals this flag ANDed with control bit 1. Any write to 0Dh clears the flag.
- R10: Status bit 0 is high during a transfer. While it is high, writes to every address except 0Dh are ignored, including alias writes that would start another transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cs_o | output | 8 | Active-high chip selects |
| sk_o | output | 1 | Serial clock |
| do_o | output | 1 | Serial data out |
| di_i | input | 1 | Serial data in |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default eight selects and an 8-bit divider. It sweeps all eight alias addresses, both transfer widths and divider values 0, 1 and 3, which covers every select index and both byte paths. At each divider value it measures the phase widths and the guard intervals. A bench slave returns a known pattern, so the receive path and the untouched second byte in 8-bit mode can be checked. Separate runs cover the rejected second start, the interrupt gating and the software-select transfer.

// File: rtl/mwcs_pkg.sv
// Shared constants and types for the serial master with auto chip-select.
package mwcs_pkg;
    localparam int ADDR_W  = 4;
    localparam logic [ADDR_W-1:0] A_SB     = 4'h0;
    localparam logic [ADDR_W-1:0] A_FB     = 4'h1;
    localparam logic [ADDR_W-1:0] A_ALIAS0 = 4'h2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'hA;
    localparam logic [ADDR_W-1:0] A_DIV    = 4'hB;
    localparam logic [ADDR_W-1:0] A_CSR    = 4'hC;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;
endpackage

// File: rtl/mwcs_tick_gen.sv
// Half-period tick generator.
// Emits a one-cycle tick every DIV+1 cycles while enabled.
// Assumes div is stable while en is high.
module mwcs_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Count cycles, restarting on each tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mwcs_shifter.sv
// Transfer sequencer and shift register.
// Sequence: lead guard (2 ticks), 2 ticks per bit, trail guard (2 ticks).
// The word goes out MSB first. In 8-bit mode only tx[15:8] is sent, and
// the received byte lands in rx[7:0].
// Assumes start is only raised while busy is low.
module mwcs_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic              tick,
    input  logic [WORD_W-1:0] tx,
    input  logic              di,
    output logic              busy,
    output logic              sk,
    output logic              dout,
    output logic              done,
    output logic [WORD_W-1:0] rx
);
    import mwcs_pkg::*;

    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W);

    seq_state_t        state;
    logic              guard_ph;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] sr;
    logic              smp;
    logic              wide_q;
    logic [CNT_W-1:0]  last_bit;

    assign busy     = (state != ST_IDLE);
    assign dout     = (state == ST_SHIFT) ? sr[WORD_W-1] : 1'b0;
    assign rx       = sr;
    assign last_bit = wide_q ? CNT_W'(WORD_W - 1) : CNT_W'(HALF_W - 1);

    // Step the sequence on each divider tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            guard_ph <= 1'b0;
            bit_cnt  <= '0;
            sr       <= '0;
            smp      <= 1'b0;
            wide_q   <= 1'b0;
            sk       <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    sr       <= wide ? tx : {tx[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
                    wide_q   <= wide;
                    guard_ph <= 1'b0;
                    bit_cnt  <= '0;
                    state    <= ST_LEAD;
                end
                ST_LEAD: if (tick) begin
                    guard_ph <= !guard_ph;
                    if (guard_ph) state <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!sk) begin
                        sk  <= 1'b1;
                        smp <= di;
                    end else begin
                        sk <= 1'b0;
                        sr <= {sr[WORD_W-2:0], smp};
                        if (bit_cnt == last_bit) begin
                            bit_cnt <= '0;
                            state   <= ST_TRAIL;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TRAIL: if (tick) begin
                    guard_ph <= !guard_ph;
                    if (guard_ph) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mwcs_top.sv
// Serial master with eight chip selects, software and hardware framing.
// Holds the register file and address decode, and merges the software
// select register with the hardware select of the active transfer.
// Assumes a single-cycle write strobe and a combinational read.
module mwcs_top #(
    parameter int NUM_CS = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CS-1:0] cs_o,
    output logic              sk_o,
    output logic              do_o,
    input  logic              di_i,
    output logic              irq_o
);
    import mwcs_pkg::*;

    localparam int IDX_W = $clog2(NUM_CS);

    logic [7:0]        fb, sb;
    logic              ctrl_wide, ctrl_ien, xfer_wide;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CS-1:0] sw_cs, hw_mask;
    logic              done_flag, hw_active;
    logic [IDX_W-1:0]  hw_idx;
    logic              busy, tick, xfer_done;
    logic [15:0]       rx;
    logic              alias_hit, fb_hit, start;
    logic [3:0]        alias_off;

    assign alias_off = addr - A_ALIAS0;
    assign alias_hit = (addr >= A_ALIAS0) && (32'(alias_off) < NUM_CS);
    assign fb_hit    = (addr == A_FB);
    assign start     = wr_en && !busy && (alias_hit || fb_hit);

    mwcs_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .div(div_q), .tick(tick)
    );

    mwcs_shifter #(.WORD_W(16)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(ctrl_wide),
        .tick(tick), .tx({wdata, sb}), .di(di_i), .busy(busy),
        .sk(sk_o), .dout(do_o), .done(xfer_done), .rx(rx)
    );

    // Register writes, transfer framing and completion write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb <= '0; sb <= '0;
            ctrl_wide <= 1'b0; ctrl_ien <= 1'b0; xfer_wide <= 1'b0;
            div_q <= '0; sw_cs <= '0;
            done_flag <= 1'b0; hw_active <= 1'b0; hw_idx <= '0;
        end else begin
            if (xfer_done) begin
                done_flag <= 1'b1;
                hw_active <= 1'b0;
                if (xfer_wide) begin
                    fb <= rx[15:8];
                    sb <= rx[7:0];
                end else begin
                    fb <= rx[7:0];
                end
            end
            if (wr_en && addr == A_STAT)
                done_flag <= 1'b0;
            if (wr_en && !busy) begin
                if (addr == A_SB)   sb <= wdata;
                if (addr == A_CTRL) {ctrl_ien, ctrl_wide} <= wdata[1:0];
                if (addr == A_DIV)  div_q <= wdata[DIV_W-1:0];
                if (addr == A_CSR)  sw_cs <= wdata[NUM_CS-1:0];
            end
            if (start) begin
                fb        <= wdata;
                xfer_wide <= ctrl_wide;
                done_flag <= 1'b0;
                hw_active <= alias_hit;
                hw_idx    <= alias_off[IDX_W-1:0];
            end
        end
    end

    // One select line per alias position.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_hw_sel
        assign hw_mask[i] = hw_active && (hw_idx == IDX_W'(i));
    end

    assign cs_o  = sw_cs | hw_mask;
    assign irq_o = done_flag && ctrl_ien;

    // Combinational register read mux.
    always_comb begin
        rdata = 8'h00;
        if (alias_hit || fb_hit) rdata = fb;
        else case (addr)
            A_SB:    rdata = sb;
            A_CTRL:  rdata = {6'b0, ctrl_ien, ctrl_wide};
            A_DIV:   rdata = 8'(div_q);
            A_CSR:   rdata = 8'(sw_cs);
            A_STAT:  rdata = {6'b0, done_flag, busy};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/mwcs_chk.sv
// Timing and framing checker for mwcs_top, attached by bind.
module mwcs_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_o,
    input logic              sk_o,
    input logic              irq_o,
    input logic              busy,
    input logic              hw_active,
    input logic              xfer_done,
    input logic              wr_en,
    input logic [3:0]        addr
);
    // R8: serial clock rests low outside a transfer.
    a_r8_sk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sk_o);

    // R5: selects never move while the serial clock is high.
    a_r5_cs_moves_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_o) |-> (!sk_o && !$past(sk_o)));

    // R10: selects are frozen for the whole of a running transfer.
    a_r10_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_o));

    // R4: a hardware frame only exists around a running transfer.
    a_r4_frame_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        hw_active |-> (busy || $fell(busy)));

    // R9: the interrupt rises only after completion or an enable write.
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(xfer_done) || $past(wr_en && addr == 4'hA)));
endmodule

bind mwcs_top mwcs_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_o(cs_o), .sk_o(sk_o), .irq_o(irq_o),
    .busy(busy), .hw_active(hw_active), .xfer_done(xfer_done),
    .wr_en(wr_en), .addr(addr)
);

// File: tb/tb_mwcs_top.sv
module tb_mwcs_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] cs_o;
    logic       sk_o, do_o, irq_o;
    logic       di_i;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [15:0] slave_pat = 16'h0000;

    // monitor state (owned by the monitor process)
    logic [7:0]  cs_prev = 0, cs_or = 0;
    logic        sk_prev = 0;
    int          edge_cnt = 0, rise_cyc = 0, fall_cyc = 0, cs_rise_cyc = 0;
    int          lead = 0, trail = 0, ph_err = 0, cur_div = 0;
    logic [15:0] mosi = 0;

    mwcs_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cs_o(cs_o), .sk_o(sk_o), .do_o(do_o), .di_i(di_i),
        .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    assign di_i = slave_pat[4'd15 - edge_cnt[3:0]];

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    // observe serial activity between clock edges
    always @(negedge clk) begin
        if (cs_o != 0 && cs_prev == 0) begin
            cs_rise_cyc = cyc; edge_cnt = 0; cs_or = 0; ph_err = 0; mosi = 0;
        end
        cs_or = cs_or | cs_o;
        if (sk_o && !sk_prev) begin
            if (edge_cnt == 0) lead = cyc - cs_rise_cyc;
            else if (cyc - fall_cyc != cur_div + 1) ph_err++;
            edge_cnt++; rise_cyc = cyc;
            mosi = {mosi[14:0], do_o};
        end
        if (!sk_o && sk_prev) begin
            if (cyc - rise_cyc != cur_div + 1) ph_err++;
            fall_cyc = cyc;
        end
        if (cs_o == 0 && cs_prev != 0) trail = cyc - fall_cyc;
        cs_prev = cs_o; sk_prev = sk_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int t = 0; t < 5000; t++) begin
            bus_rd(4'hD, s);
            if (s[1]) return;
        end
        check(0, "R9 done timeout", 0, 1);
    endtask

    // One hardware-framed transfer with full result checks.
    task automatic hw_xfer(input int idx, input bit wide, input int d,
                           input logic [7:0] fbv, input logic [7:0] sbv,
                           input logic [15:0] pat);
        logic [7:0] r;
        int nb;
        nb = wide ? 16 : 8;
        cur_div = d;
        bus_wr(4'hB, 8'(d));
        bus_wr(4'hA, {6'b0, 1'b1, wide});
        bus_wr(4'h0, sbv);
        slave_pat = pat;
        bus_wr(4'(2 + idx), fbv);
        wait_done();
        check(irq_o === 1'b1, "R9 irq on completion", int'(irq_o), 1);
        check(cs_or == 8'(1 << idx), "R4 only selected cs", cs_or, 1 << idx);
        check(cs_o == 0, "R4 cs released", cs_o, 0);
        check(edge_cnt == nb, "R4 edge count", edge_cnt, nb);
        if (wide) check(mosi == {fbv, sbv}, "R5 out order 16", mosi, {fbv, sbv});
        else      check(mosi[7:0] == fbv, "R5 out order 8", mosi[7:0], fbv);
        check(ph_err == 0, "R7 phase width", ph_err, 0);
        check(lead >= 2 * (d + 1), "R8 lead guard", lead, 2 * (d + 1));
        check(trail >= 2 * (d + 1), "R8 trail guard", trail, 2 * (d + 1));
        bus_rd(4'h1, r);
        check(r == pat[15:8], "R6 first byte rx", r, pat[15:8]);
        bus_rd(4'(2 + idx), r);
        check(r == pat[15:8], "R3 alias read", r, pat[15:8]);
        bus_rd(4'h0, r);
        if (wide) check(r == pat[7:0], "R6 second byte rx", r, pat[7:0]);
        else      check(r == sbv, "R6 second byte kept", r, sbv);
        bus_wr(4'hD, 8'h00);
        check(irq_o === 1'b0, "R9 irq cleared", int'(irq_o), 0);
    endtask

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(cs_o == 0 && sk_o == 0 && do_o == 0 && irq_o == 0, "R1 outputs",
              {cs_o, sk_o, do_o, irq_o}, 0);
        bus_rd(4'hD, r);
        check(r == 0, "R1 status", r, 0);

        // R2 software select register
        bus_wr(4'hC, 8'hA5);
        check(cs_o == 8'hA5, "R2 sw cs drive", cs_o, 8'hA5);
        bus_rd(4'hC, r);
        check(r == 8'hA5, "R2 sw cs readback", r, 8'hA5);
        bus_wr(4'hC, 8'h00);
        check(cs_o == 8'h00, "R2 sw cs clear", cs_o, 0);

        // R4/R5/R6/R7/R8 sweep: all aliases, both widths, three dividers
        foreach (slave_pat[i]) begin end
        for (int d = 0; d < 4; d++) begin
            if (d == 2) continue;
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 8; k++)
                    hw_xfer(k, w[0], d, 8'(8'h5A ^ (k * 37 + d * 11 + w)),
                            8'(8'hC3 + k * 13 + d), 16'(16'hB61D ^ (k * 4099 + d * 257 + w * 31)));
        end

        // R10 second start while busy is ignored
        cur_div = 1;
        bus_wr(4'hA, 8'h03);
        bus_wr(4'h0, 8'h3C);
        slave_pat = 16'h9E47;
        bus_wr(4'h4, 8'h11);
        bus_rd(4'hD, r);
        check(r[0] == 1'b1, "R10 busy flag", r, 1);
        bus_wr(4'h7, 8'h99);
        bus_wr(4'h0, 8'h77);
        bus_wr(4'hC, 8'hFF);
        wait_done();
        check(cs_or == 8'h04, "R10 no other cs", cs_or, 8'h04);
        bus_rd(4'h1, r);
        check(r == 8'h9E, "R10 fb not overwritten", r, 8'h9E);
        bus_rd(4'h0, r);
        check(r == 8'h47, "R10 sb not overwritten", r, 8'h47);
        check(cs_o == 0, "R10 csr write ignored", cs_o, 0);
        repeat (100) @(negedge clk);
        check(edge_cnt == 16, "R10 no second transfer", edge_cnt, 16);
        bus_rd(4'hD, r);
        check(r[0] == 1'b0, "R10 busy clear", r, 0);
        bus_wr(4'hD, 8'h00);

        // R9 interrupt enable gating
        cur_div = 0;
        bus_wr(4'hA, 8'h00);
        bus_wr(4'h3, 8'h42);
        wait_done();
        check(irq_o === 1'b0, "R9 irq masked", int'(irq_o), 0);
        bus_wr(4'hA, 8'h02);
        check(irq_o === 1'b1, "R9 irq enabled later", int'(irq_o), 1);
        bus_wr(4'hD, 8'h00);
        check(irq_o === 1'b0, "R9 irq clear", int'(irq_o), 0);

        // R3 software-framed transfer via first-byte address
        bus_wr(4'hC, 8'h80);
        slave_pat = 16'h6B00;
        bus_wr(4'h1, 8'hD2);
        wait_done();
        check(cs_o == 8'h80, "R3 sw frame held", cs_o, 8'h80);
        check(edge_cnt == 8 && mosi[7:0] == 8'hD2, "R3 sw transfer data", mosi[7:0], 8'hD2);
        bus_rd(4'h1, r);
        check(r == 8'h6B, "R3 sw transfer rx", r, 8'h6B);
        finish_run();
    end
endmodule